// File: doc/BRIEF.md
# Blanked Voltage-Mode PWM Controller

This block is a fixed-frequency pulse-width modulator that drives the enable of a single power switch. A free-running ramp counter sets the switching period. At the first cycle of every period the switch is turned on, and the error word is captured for that period. The on-time then shrinks as the error word grows. A larger error word gives a shorter pulse.

The pulse can end in three ways. The first is the error-derived end point. The second is a hard maximum-duty point placed well before the end of the ramp. The third is an overcurrent flag from an external comparator. The overcurrent flag is ignored during a blanking window just after turn-on. Past that window it ends the pulse after a fixed detection delay, and the switch stays off for the rest of the period. A minimum on-time makes sure that every enabled period still delivers a short pulse, even at the largest error values. When the enable input drops, the gate is forced low in the same cycle.

The error word and the overcurrent flag are plain level inputs sampled by the block. There is no handshake and no back-pressure at either edge. All timings are parameters in clock cycles. The defaults assume a 100 MHz clock: a 1000-cycle period, a 670-cycle maximum on-time, a 20-cycle minimum, 15 cycles of blanking and a 10-stage overcurrent delay.

Top module: `pwm_vm_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_en` is low. The first period starts at the first rising clock edge after reset is released, so `gate_en` is high in the cycle that follows that edge when `enable` is high.
- R2: Rising edges of `gate_en` in consecutive enabled periods are exactly `PERIOD` cycles apart.
- R3: The on-time of a period is `MAX_ON - err`, where `err` is the unsigned error word captured at the period start, whenever that value is at least `MIN_ON`.
- R4: `gate_en` is never high at a ramp count of `MAX_ON` or above. With `err = 0` the on-time is exactly `MAX_ON` cycles.
- R5: When `MAX_ON - err` is below `MIN_ON`, which includes any `err` of `MAX_ON` or more, the on-time is exactly `MIN_ON` cycles.
- R6: The error word is captured only at the period start. A change part-way through a period leaves the current pulse unchanged and takes effect in the next period.
- R7: When `enable` is low, `gate_en` is low in the same cycle. After `enable` returns high part-way through a period, `gate_en` stays low until the next period start.
- R8: An overcurrent flag that is high only while the ramp count is below `BLANK` has no effect on the pulse.
- R9: An overcurrent flag that is high in the cycle at ramp count k, with k at least `BLANK` and the gate on, makes `gate_en` low from count k+`CL_DLY`+1. The gate then stays low until the next period start.
- R10: The period after an overcurrent termination starts on time and runs its normal error-derived on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable. Low forces the gate off at once and clears the output latch |
| err_in | input | ERR_W | Unsigned error word. Larger values give a shorter on-time |
| oc_flag | input | 1 | Overcurrent comparator flag, active high |
| gate_en | output | 1 | Enable for the power switch gate |

## Verification
Some properties are checked on every cycle. A rising gate always lands on ramp count zero. The gate is never on at or past the maximum-duty count. A low enable always means a low gate. Once the gate is off inside a period it cannot come back on before the period wraps. During the blanking window a lit gate stays lit unless enable drops. The exact pulse widths need the directed scenarios. These cover the inverse mapping from error to on-time, the clamp at the minimum on-time, the deferred use of a mid-period error change, the turn-off point k+`CL_DLY`+1 after a late overcurrent flag, and the clean restart after it.

// File: rtl/pwm_vm_pkg.sv
package pwm_vm_pkg;

  // On-time in cycles for a captured error word: inverse linear law,
  // clamped below by the minimum pulse width.
  function automatic int unsigned on_cycles(input int unsigned err,
                                            input int unsigned max_on,
                                            input int unsigned min_on);
    if (err + min_on >= max_on) return min_on;
    return max_on - err;
  endfunction

endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int unsigned PERIOD = 1000,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  // Reset to the last count so the first edge after reset opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= LAST;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign wrap = (cnt == LAST);
endmodule

// File: rtl/pwm_ontime.sv
module pwm_ontime
  import pwm_vm_pkg::*;
#(
  parameter int unsigned ERR_W  = 10,
  parameter int unsigned CW     = 10,
  parameter int unsigned MAX_ON = 670,
  parameter int unsigned MIN_ON = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ERR_W-1:0] err_in,
  output logic [CW-1:0]    ton_q
);
  logic [CW-1:0] ton_d;

  always_comb begin
    ton_d = CW'(on_cycles(32'(err_in), MAX_ON, MIN_ON));
  end

  // Captured once per period, at the same edge that turns the switch on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ton_q <= CW'(MIN_ON);
    else if (start) ton_q <= ton_d;
  end
endmodule

// File: rtl/pwm_climit.sv
module pwm_climit #(
  parameter int unsigned CW     = 10,
  parameter int unsigned BLANK  = 15,
  parameter int unsigned CL_DLY = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          armed,
  input  logic [CW-1:0] cnt,
  input  logic          oc_flag,
  output logic          trip
);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK);

  logic          det;
  logic [CL_DLY-1:0] dly;

  assign det = armed & oc_flag & (cnt >= BLANK_C);

  generate
    if (CL_DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dly <= '0;
        else if (clr) dly <= '0;
        else          dly <= det;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dly <= '0;
        else if (clr) dly <= '0;
        else          dly <= {dly[CL_DLY-2:0], det};
      end
    end
  endgenerate

  assign trip = dly[CL_DLY-1];
endmodule

// File: rtl/pwm_vm_ctrl.sv
module pwm_vm_ctrl #(
  parameter int unsigned PERIOD = 1000,
  parameter int unsigned ERR_W  = 10,
  parameter int unsigned MAX_ON = 670,
  parameter int unsigned MIN_ON = 20,
  parameter int unsigned BLANK  = 15,
  parameter int unsigned CL_DLY = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [ERR_W-1:0] err_in,
  input  logic             oc_flag,
  output logic             gate_en
);
  localparam int unsigned   CW       = $clog2(PERIOD);
  localparam logic [CW:0]   MAX_ON_C = (CW+1)'(MAX_ON);

  logic [CW-1:0] ramp_cnt;
  logic          ramp_wrap;
  logic [CW-1:0] ton_q;
  logic          oc_trip;
  logic          gate_q;
  logic [CW:0]   cnt_nxt;

  pwm_ramp #(.PERIOD(PERIOD), .CW(CW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .cnt(ramp_cnt), .wrap(ramp_wrap)
  );

  pwm_ontime #(.ERR_W(ERR_W), .CW(CW), .MAX_ON(MAX_ON), .MIN_ON(MIN_ON)) u_ontime (
    .clk(clk), .rst_n(rst_n), .start(ramp_wrap), .err_in(err_in), .ton_q(ton_q)
  );

  pwm_climit #(.CW(CW), .BLANK(BLANK), .CL_DLY(CL_DLY)) u_climit (
    .clk(clk), .rst_n(rst_n), .clr(ramp_wrap | ~enable),
    .armed(gate_q & enable), .cnt(ramp_cnt), .oc_flag(oc_flag), .trip(oc_trip)
  );

  assign cnt_nxt = {1'b0, ramp_cnt} + 1'b1;

  // Output latch: set by the period start, reset by the error end point,
  // the maximum-duty point or an overcurrent trip; disable clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gate_q <= 1'b0;
    else if (!enable)                   gate_q <= 1'b0;
    else if (ramp_wrap)                 gate_q <= 1'b1;
    else if (oc_trip)                   gate_q <= 1'b0;
    else if (cnt_nxt >= {1'b0, ton_q})  gate_q <= 1'b0;
    else if (cnt_nxt >= MAX_ON_C)       gate_q <= 1'b0;
  end

  assign gate_en = gate_q & enable;
endmodule

// File: rtl/pwm_vm_ctrl_chk.sv
module pwm_vm_ctrl_chk #(
  parameter int unsigned PERIOD = 1000,
  parameter int unsigned CW     = 10,
  parameter int unsigned MAX_ON = 670,
  parameter int unsigned BLANK  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          gate_en,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST_C  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] MAXON_C = CW'(MAX_ON);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK);

  p_rise_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (cnt == '0));

  p_max_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> (cnt < MAXON_C));

  p_disable_forces_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !gate_en);

  p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && cnt < BLANK_C) |=> (gate_en || !enable));

  p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && cnt != LAST_C) |=> !gate_en);
endmodule

bind pwm_vm_ctrl pwm_vm_ctrl_chk #(
  .PERIOD(PERIOD), .CW(CW), .MAX_ON(MAX_ON), .BLANK(BLANK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gate_en(gate_en), .cnt(ramp_cnt)
);

// File: tb/pwm_vm_ctrl_tb_top.sv
module pwm_vm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 1000, MAX_ON = 670, MIN_ON = 20, BLANK = 15, CL_DLY = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic [9:0] err_in = 10'd300;
  logic       oc_flag = 1'b0;
  logic       gate_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_vm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .err_in(err_in),
    .oc_flag(oc_flag), .gate_en(gate_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the falling edge of the cycle at ramp count 0 with the gate on.
  // Drives the flag high for counts in [oc_from, oc_to), returns the number of
  // high cycles and the cycles until the next rise.
  task automatic run_period(input int oc_from, input int oc_to,
                            output int width, output int per);
    int  i = 0;
    bit  seen_low = 0;
    width = 0;
    forever begin
      oc_flag = (i >= oc_from && i < oc_to);
      if (gate_en) width++;
      @(negedge clk);
      i++;
      if (!gate_en) seen_low = 1;
      if ((seen_low && gate_en) || i > 3 * PERIOD) break;
    end
    oc_flag = 1'b0;
    per = i;
  endtask

  task automatic t_reset;
    int w, p;
    repeat (5) @(negedge clk);
    chk("R1 low in reset", gate_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first period starts", gate_en, 1);
    run_period(0, 0, w, p);
    chk("R3 width err=300", w, 370);
    chk("R2 period", p, PERIOD);
  endtask

  task automatic t_width(input int e, input int exp, input string req);
    int w, p;
    err_in = 10'(e);
    run_period(0, 0, w, p);
    run_period(0, 0, w, p);
    chk(req, w, exp);
    chk("R2 period", p, PERIOD);
  endtask

  task automatic t_midchange;
    int w, p;
    err_in = 10'd300;
    run_period(0, 0, w, p);
    err_in = 10'd500;
    run_period(0, 0, w, p);
    chk("R6 current pulse keeps old word", w, 370);
    run_period(0, 0, w, p);
    chk("R6 next pulse uses new word", w, 170);
  endtask

  task automatic t_enable;
    int w, p, n;
    bit stayed_low = 1;
    err_in = 10'd300;
    repeat (50) @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R7 low same cycle", gate_en, 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    n = 0;
    while (!gate_en && n < 2 * PERIOD) begin
      @(negedge clk);
      n++;
    end
    chk("R7 resumes at next period start", n, PERIOD - 55);
    run_period(0, 0, w, p);
    chk("R7 normal pulse after resume", w, 370);
    if (p != PERIOD) stayed_low = 0;
    chk("R7 period after resume", int'(stayed_low), 1);
  endtask

  task automatic t_oc;
    int w, p;
    err_in = 10'd300;
    run_period(3, 13, w, p);
    chk("R8 flag in blanking ignored", w, 370);
    run_period(100, 101, w, p);
    chk("R9 late flag turn-off", w, 100 + CL_DLY + 1);
    chk("R9 period kept", p, PERIOD);
    run_period(0, 0, w, p);
    chk("R10 normal pulse after trip", w, 370);
    run_period(0, 2 * PERIOD, w, p);
    chk("R9 flag held high", w, BLANK + CL_DLY + 1);
    run_period(0, 2 * PERIOD, w, p);
    chk("R9 flag held high again", w, BLANK + CL_DLY + 1);
    chk("R10 period under trip", p, PERIOD);
  endtask

  initial begin
    t_reset();
    t_width(0,    MAX_ON,     "R4 err=0 max duty");
    t_width(649,  21,         "R3 err=649");
    t_width(650,  MIN_ON,     "R5 err at min boundary");
    t_width(660,  MIN_ON,     "R5 err clamped");
    t_width(1023, MIN_ON,     "R5 err full scale");
    t_width(100,  570,        "R3 err=100");
    t_midchange();
    t_enable();
    t_oc();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule